// File: doc/BRIEF.md
# Bus Enumeration Hello Responder

This block is the device-side half of host-driven discovery on a shared multi-drop serial bus. A frame parser upstream presents each decoded command as a destination address, a command code and a 32-bit argument, qualified by a one-cycle valid. When the host broadcasts a hello to address zero, the block stores the host address carried in the argument. It then waits a random number of time slots, checks that the bus is idle, and asks the frame transmitter to send a hello reply to that stored address.

A shut-up command addressed to the device's own 32-bit address sets a silence latch that only reset clears. While the latch is set, broadcast hellos are ignored. The host can therefore repeat its broadcast until no device that is still unsilenced answers. The random wait is counted in slots of `TICK_DIV` clock cycles, and the slot count is drawn from a free-running LFSR. At the default settings on a 100 MHz clock the wait spans from 0 to just under 0.5 s.

The reply request to the transmitter is a valid/ready stream. Once `reply_valid` rises, it stays high and `reply_dest` stays constant until a cycle in which `reply_ready` is high. The request is withdrawn after that handshake edge. The command input has no back-pressure: every command is decoded in the cycle its valid is high.

Top module: `hello_responder`

## Requirements
- R1: After reset, `reply_valid` is 0 and the device is not silenced, so the first broadcast hello is answered.
- R2: A command with `cmd_valid`=1, `cmd_dest`=0 and `cmd_code`=`CMD_HELLO` (default 0x01) starts a reply wait when the device is not silenced and holds no offered reply. `cmd_arg` is stored and later appears on `reply_dest`.
- R3: With the bus idle, `reply_valid` rises 1 + k·`TICK_DIV` clock edges after the edge that accepted the hello. Here k is a pseudo-random slot count in 0..2^`RAND_W`−1, and successive hellos draw different values of k.
- R4: While `bus_busy` is 1, no reply is offered. After the wait has expired, `reply_valid` rises on the edge after the first cycle in which `bus_busy` is sampled 0.
- R5: `reply_valid` and `reply_dest` hold steady until `reply_ready` is 1. `reply_valid` falls on the edge that samples `reply_valid`=1 together with `reply_ready`=1.
- R6: A broadcast hello that arrives while a wait is running restarts the wait with a fresh random slot count and the new `cmd_arg`.
- R7: A broadcast hello that arrives while a reply is being offered is discarded, and `reply_dest` keeps its value.
- R8: A command with `cmd_dest` equal to `OWN_ADDR` and `cmd_code`=`CMD_SHUT` (default 0x02) sets the silence latch. It also cancels a wait that has not yet been offered, and every later hello goes unanswered.
- R9: A shut-up sent to any other address, and a hello sent to any address other than 0, have no effect.
- R10: Only reset clears the silence latch. After reset, a broadcast hello is answered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_dest | input | ADDR_W | Destination address of the command |
| cmd_code | input | CMD_W | Command code |
| cmd_arg | input | ADDR_W | Command argument (host address for hello) |
| bus_busy | input | 1 | Shared bus currently carries traffic |
| reply_valid | output | 1 | Hello reply requested from the transmitter |
| reply_ready | input | 1 | Transmitter accepts the reply request |
| reply_dest | output | ADDR_W | Host address the reply is sent to |

## Verification
On every cycle, the assertions check the stream rules: the request stays held and its address stays stable under back-pressure. They also check that an offer only ever starts after a cycle with the bus idle, that no offer starts while the device is silenced, that the silence latch never falls outside reset, and that the LFSR never locks up at zero. Other behaviour can only be shown by the bench scenarios. These are: the exact slot-aligned latency and its spread across hellos, the restart on a repeated hello, and the discard of a hello during an offer. They also include the cancellation by a shut-up, the indifference to foreign addresses, and recovery after reset.

// File: rtl/hr_pkg.sv
package hr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_OFFER = 2'd2
  } hr_state_e;
endpackage

// File: rtl/hr_lfsr.sv
module hr_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1,
  parameter int          OUT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= SEED[LFSR_W-1:0];
    else if (sr[0]) sr <= (sr >> 1) ^ TAPS[LFSR_W-1:0];
    else sr <= sr >> 1;
  end

  assign rnd_o = sr[OUT_W-1:0];

  // R3: the random source must never lock up at the all-zero state
  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    sr != '0);
endmodule

// File: rtl/hr_slot_timer.sv
module hr_slot_timer #(
  parameter int TICK_DIV = 390625,
  parameter int RAND_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [RAND_W-1:0] slots_i,
  output logic              expired_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  pre;
  logic [RAND_W-1:0] slots;

  assign expired_o = (slots == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      slots <= '0;
    end else if (load_i) begin
      pre   <= '0;
      slots <= slots_i;
    end else if (!expired_o) begin
      if (pre == PRE_LAST) begin
        pre   <= '0;
        slots <= slots - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  // R3: the slot count only moves downward unless reloaded
  a_r3_slots_descend: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !expired_o |=> slots <= $past(slots));
endmodule

// File: rtl/hello_responder.sv
module hello_responder #(
  parameter int              ADDR_W    = 32,
  parameter int              CMD_W     = 8,
  parameter logic [CMD_W-1:0] CMD_HELLO = 8'h01,
  parameter logic [CMD_W-1:0] CMD_SHUT  = 8'h02,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 32'h0000_A5C3,
  parameter int              TICK_DIV  = 390625,
  parameter int              RAND_W    = 7,
  parameter logic [15:0]     LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_dest,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [ADDR_W-1:0] cmd_arg,
  input  logic              bus_busy,
  output logic              reply_valid,
  input  logic              reply_ready,
  output logic [ADDR_W-1:0] reply_dest
);
  import hr_pkg::*;

  hr_state_e         state;
  logic              silenced;
  logic [ADDR_W-1:0] host_addr;
  logic [RAND_W-1:0] rnd;
  logic              expired;
  logic              is_hello, is_shut, start;

  assign is_hello = cmd_valid && (cmd_dest == '0) && (cmd_code == CMD_HELLO);
  assign is_shut  = cmd_valid && (cmd_dest == OWN_ADDR) && (cmd_code == CMD_SHUT);
  assign start    = is_hello && !silenced && !is_shut && (state != ST_OFFER);

  hr_lfsr #(.LFSR_W(16), .TAPS(16'hB400), .SEED(LFSR_SEED), .OUT_W(RAND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_o(rnd)
  );

  hr_slot_timer #(.TICK_DIV(TICK_DIV), .RAND_W(RAND_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(start), .slots_i(rnd), .expired_o(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      silenced  <= 1'b0;
      host_addr <= '0;
    end else begin
      if (is_shut) silenced <= 1'b1;
      case (state)
        ST_OFFER: if (reply_ready) state <= ST_IDLE;
        default: begin
          if (is_shut) begin
            state <= ST_IDLE;
          end else if (start) begin
            state     <= ST_WAIT;
            host_addr <= cmd_arg;
          end else if (state == ST_WAIT && expired && !bus_busy) begin
            state <= ST_OFFER;
          end
        end
      endcase
    end
  end

  assign reply_valid = (state == ST_OFFER);
  assign reply_dest  = host_addr;

  // R5: request held under back-pressure
  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid && !reply_ready |=> reply_valid);
  // R5: destination stable while offered
  a_r5_hold_dest: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid && !reply_ready |=> $stable(reply_dest));
  // R4: an offer begins only after an idle-bus cycle
  a_r4_idle_before_offer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply_valid) |-> !$past(bus_busy));
  // R8: a silenced device never starts an offer
  a_r8_no_offer_silenced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply_valid) |-> !silenced);
  // R10: the silence latch is sticky outside reset
  a_r10_sticky_silence: assert property (@(posedge clk) disable iff (!rst_n)
    silenced |=> silenced);
endmodule

// File: tb/hello_responder_test.sv
module hello_responder_test;
  localparam int TD = 3;
  localparam int RW = 4;
  localparam int MAXLAT = ((1 << RW) - 1) * TD + 1;
  localparam logic [31:0] OWN = 32'h0000_A5C3;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, bus_busy = 0, reply_ready = 0;
  logic [31:0] cmd_dest = 0, cmd_arg = 0;
  logic [7:0]  cmd_code = 0;
  logic        reply_valid;
  logic [31:0] reply_dest;
  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  hello_responder #(.TICK_DIV(TD), .RAND_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg), .bus_busy(bus_busy),
    .reply_valid(reply_valid), .reply_ready(reply_ready), .reply_dest(reply_dest)
  );

  function automatic bit lat_ok(int n);
    return n >= 1 && n <= MAXLAT && ((n - 1) % TD) == 0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] d, logic [7:0] c, logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_dest = d; cmd_code = c; cmd_arg = a;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // counts edges until reply_valid seen, up to lim; returns 0 if none
  task automatic wait_reply(int lim, output int lat);
    lat = 0;
    for (int i = 1; i <= lim; i++) begin
      if (i > 1) @(negedge clk);
      if (i == 1) @(negedge clk);
      if (reply_valid) begin lat = i; return; end
    end
  endtask

  task automatic accept;
    @(negedge clk); reply_ready = 1;
    @(negedge clk); reply_ready = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat, first_lat;
    bit spread;
    logic [31:0] a;
    void'($urandom(32'd1234));
    do_reset();
    check(reply_valid == 0, "R1 reset valid", reply_valid, 0);

    // R1/R2/R3 first hello answered with slot-aligned latency
    send(32'h0, 8'h01, 32'h1111_2222);
    wait_reply(MAXLAT + 5, lat);
    check(lat_ok(lat), "R3 latency", lat, MAXLAT);
    check(reply_dest == 32'h1111_2222, "R2 dest", reply_dest, 32'h1111_2222);
    // R5 hold under back-pressure
    repeat (4) @(negedge clk);
    check(reply_valid == 1, "R5 hold valid", reply_valid, 1);
    check(reply_dest == 32'h1111_2222, "R5 hold dest", reply_dest, 32'h1111_2222);
    // R7 hello during offer discarded
    send(32'h0, 8'h01, 32'h3333_4444);
    check(reply_valid && reply_dest == 32'h1111_2222, "R7 discard", reply_dest, 32'h1111_2222);
    accept();
    check(reply_valid == 0, "R5 drop after ready", reply_valid, 0);

    // R3 random spread across several hellos
    first_lat = -1; spread = 0;
    for (int t = 0; t < 8; t++) begin
      a = $urandom();
      repeat ($urandom_range(0, 5)) @(negedge clk);
      send(32'h0, 8'h01, a);
      wait_reply(MAXLAT + 5, lat);
      check(lat_ok(lat), "R3 random latency", lat, MAXLAT);
      check(reply_dest == a, "R2 random dest", reply_dest, a);
      if (first_lat < 0) first_lat = lat; else if (lat != first_lat) spread = 1;
      accept();
    end
    check(spread, "R3 latency varies", spread, 1);

    // R4 bus busy defers; reply one edge after idle
    @(negedge clk); bus_busy = 1;
    send(32'h0, 8'h01, 32'h5555_0001);
    wait_reply(MAXLAT + 10, lat);
    check(lat == 0, "R4 no reply while busy", lat, 0);
    bus_busy = 0;
    @(negedge clk);
    check(reply_valid == 1, "R4 reply after idle", reply_valid, 1);
    accept();

    // R6 restart on repeated hello
    send(32'h0, 8'h01, 32'h6666_0001);
    send(32'h0, 8'h01, 32'h6666_0002);
    wait_reply(MAXLAT + 5, lat);
    check(lat_ok(lat), "R6 restart latency", lat, MAXLAT);
    check(reply_dest == 32'h6666_0002, "R6 new dest", reply_dest, 32'h6666_0002);
    accept();

    // R9 foreign addresses ignored
    send(32'h0000_0005, 8'h01, 32'h7777_0000);
    wait_reply(MAXLAT + 5, lat);
    check(lat == 0, "R9 unicast hello ignored", lat, 0);
    send(OWN + 1, 8'h02, 32'h0);
    send(32'h0, 8'h01, 32'h7777_0001);
    wait_reply(MAXLAT + 5, lat);
    check(lat_ok(lat), "R9 foreign shut ignored", lat, MAXLAT);
    accept();

    // R8 shut-up cancels pending wait and silences
    bus_busy = 1;
    send(32'h0, 8'h01, 32'h8888_0001);
    send(OWN, 8'h02, 32'h0);
    bus_busy = 0;
    wait_reply(MAXLAT + 5, lat);
    check(lat == 0, "R8 wait cancelled", lat, 0);
    for (int t = 0; t < 3; t++) begin
      send(32'h0, 8'h01, $urandom());
      wait_reply(MAXLAT + 5, lat);
      check(lat == 0, "R8 silenced repeat", lat, 0);
    end

    // R10 reset clears silence
    do_reset();
    check(reply_valid == 0, "R1 reset again", reply_valid, 0);
    send(32'h0, 8'h01, 32'h9999_0001);
    wait_reply(MAXLAT + 5, lat);
    check(lat_ok(lat), "R10 answered after reset", lat, MAXLAT);
    accept();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule